// File: doc/BRIEF.md
# Five-Lane Serial Video Receive Deserializer and Word Aligner

This block sits behind five double-rate input cells that each hand over four serial bits per fast clock cycle. Four lanes carry pixel data and the fifth carries a serialized copy of the pixel clock. The block packs every lane's nibble stream into 7-bit words using one bit counter that all lanes share. It then slides a 7-position window across two consecutive words of the clock lane until the slice equals the clock shape `1100011`. The bit offset found there is applied to all four data lanes, so each output beat holds four words from the same pixel.

A lock is declared only after the clock shape has been seen at the same offset for a set number of consecutive pixels. A locked link survives isolated clock-lane errors and gives up after a set number of consecutive errors. The search restarts whenever the PLL reports loss of lock. Data is presented as one 28-bit pixel with a one-cycle valid strobe, at a rate of four pixels every seven input cycles.

Top module: `lvds_rx_align`

## Requirements
- R1: After synchronous reset the `aligned` and `out_vld` outputs are low.
- R2: Bit 3 of each input nibble is the earliest received bit. The earliest bit of a pixel word lands in bit 6 of its 7-bit field. Data lane l occupies bits [7l+6:7l] of `out_word`.
- R3: For any stream bit offset from 0 to 13, the pixels delivered after lock equal the transmitted pixels, in order and with no pixel skipped.
- R4: The alignment offset is the slice position at which the clock-lane word equals `1100011`. The same offset selects the data-lane words, and it does not change while aligned.
- R5: `aligned` rises on the pixel that gives the LOCK_COUNT-th (default 4) consecutive match at one offset. That pixel is the first one delivered, and no pixel is delivered before it.
- R6: A clock-lane mismatch while lock is being confirmed discards the partial count, and the search restarts on the next pixel.
- R7: A single clock-lane mismatch while aligned keeps `aligned` high, and the pixel is still delivered.
- R8: MISS_LIMIT (default 2) consecutive mismatches while aligned drop `aligned`. The search then restarts, and a new lock needs LOCK_COUNT fresh matches.
- R9: When `pll_lock` is low at a clock edge, `aligned` and `out_vld` are low after that edge, and alignment restarts from scratch once lock returns.
- R10: `out_vld` is never high while `aligned` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, one nibble per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pll_lock | input | 1 | PLL lock status; low restarts alignment |
| data_nib | input | 16 | Data-lane nibbles, lane l at [4l+3:4l], bit 3 earliest |
| clk_nib | input | 4 | Clock-lane nibble, bit 3 earliest |
| out_word | output | 28 | Aligned pixel, data lane l at [7l+6:7l] |
| out_vld | output | 1 | One-cycle strobe for a delivered pixel |
| aligned | output | 1 | Link is locked to a pixel boundary |

## Verification
The stream is shifted by every bit offset from 0 to 13 so that each of the seven slice positions is used with two gearbox phases. Each sweep confirms that the first delivered pixel is pixel 3 and that the pixels that follow are contiguous. Lane 0 carries the pixel index, and the other lanes carry distinct linear functions of it. A swapped lane, a reversed bit order or a skipped pixel therefore shows up as a mismatch. The clock lane is blanked for one pixel during confirmation, for one pixel after lock and for two pixels after lock. Each case predicts a different first-delivered pixel or drop count, which separates a restart, a tolerated miss and a loss of lock. Pulsing `pll_lock` low checks the immediate drop and the fresh relock.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
    localparam int NUM_DATA  = 4;
    localparam int NUM_LANES = NUM_DATA + 1;
    localparam int NIB_W     = 4;
    localparam int WORD_W    = 7;
    localparam int WIN_W     = 2 * WORD_W;
    localparam int HOLD_W    = WORD_W - 1;
    localparam int FULL_W    = HOLD_W + NIB_W;
    localparam int CNT_W     = $clog2(WORD_W);
    localparam int SH_W      = $clog2(NIB_W);
    localparam logic [WORD_W-1:0] CLK_SHAPE = 7'b1100011;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  offs_t;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } lock_st_e;

    // Slice k takes window bits [WIN_W-1-k -: WORD_W]; bit WIN_W-1 is oldest.
    function automatic word_t take_slice(input logic [WIN_W-1:0] win, input offs_t k);
        logic [WIN_W-1:0] sh;
        sh = win >> (WORD_W - int'(k));
        return sh[WORD_W-1:0];
    endfunction
endpackage

// File: rtl/rxa_gear_ctrl.sv
module rxa_gear_ctrl
    import rxa_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic            emit,
    output logic [SH_W-1:0] shift,
    output logic            raw_vld
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   fill;

    always_comb begin
        fill  = {1'b0, cnt_q} + (CNT_W+1)'(NIB_W);
        emit  = (fill >= (CNT_W+1)'(WORD_W));
        shift = emit ? SH_W'(fill - (CNT_W+1)'(WORD_W)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            raw_vld <= 1'b0;
        end else begin
            cnt_q   <= emit ? CNT_W'(fill - (CNT_W+1)'(WORD_W)) : CNT_W'(fill);
            raw_vld <= emit;
        end
    end

    // Never three words in a row: 4 words per 7 nibbles
    AST_GEAR_NO_TRIPLE: assert property (@(posedge clk) disable iff (rst)
        (raw_vld && $past(raw_vld)) |=> !raw_vld); // R2
endmodule

// File: rtl/rxa_lane_gear.sv
module rxa_lane_gear
    import rxa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib,
    input  logic             emit,
    input  logic [SH_W-1:0]  shift,
    output word_t            raw_word
);
    logic [HOLD_W-1:0] hold_q;
    logic [FULL_W-1:0] full;
    logic [FULL_W-1:0] shifted;

    always_comb begin
        full    = {hold_q, nib};
        shifted = full >> shift;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            raw_word <= '0;
        end else begin
            hold_q <= full[HOLD_W-1:0];
            if (emit) raw_word <= shifted[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/rxa_lock_fsm.sv
module rxa_lock_fsm
    import rxa_pkg::*;
#(
    parameter int LOCK_COUNT = 4,
    parameter int MISS_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    input  logic [WORD_W-1:0] match,
    output offs_t             offset,
    output logic              locked,
    output logic              emit
);
    localparam int HIT_W  = $clog2(LOCK_COUNT + 1);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    lock_st_e          st_q, st_d;
    logic [HIT_W-1:0]  hits_q, hits_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    offs_t             cand_d;
    offs_t             first_k;
    logic              found;
    logic              cand_hit;

    always_comb begin
        found   = 1'b0;
        first_k = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (match[k]) begin
                found   = 1'b1;
                first_k = CNT_W'(k);
            end
        end
        cand_hit = match[offset];
    end

    always_comb begin
        st_d   = st_q;
        hits_d = hits_q;
        miss_d = miss_q;
        cand_d = offset;
        if (step) begin
            unique case (st_q)
                ST_SEARCH: if (found) begin
                    cand_d = first_k;
                    hits_d = HIT_W'(1);
                    st_d   = ST_CONFIRM;
                end
                ST_CONFIRM: if (cand_hit) begin
                    hits_d = hits_q + HIT_W'(1);
                    if (hits_d == HIT_W'(LOCK_COUNT)) begin
                        st_d   = ST_LOCKED;
                        miss_d = '0;
                    end
                end else begin
                    st_d   = ST_SEARCH;
                    hits_d = '0;
                end
                ST_LOCKED: if (cand_hit) begin
                    miss_d = '0;
                end else if (miss_q + MISS_W'(1) == MISS_W'(MISS_LIMIT)) begin
                    st_d   = ST_SEARCH;
                    hits_d = '0;
                    miss_d = '0;
                end else begin
                    miss_d = miss_q + MISS_W'(1);
                end
                default: st_d = ST_SEARCH;
            endcase
        end
        emit = step && (st_d == ST_LOCKED);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st_q   <= ST_SEARCH;
            hits_q <= '0;
            miss_q <= '0;
            offset <= '0;
        end else begin
            st_q   <= st_d;
            hits_q <= hits_d;
            miss_q <= miss_d;
            offset <= cand_d;
        end
    end

    assign locked = (st_q == ST_LOCKED);

    AST_MISS_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        miss_q < MISS_W'(MISS_LIMIT)); // R8
    AST_LOCK_AFTER_CONFIRM: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(st_q) == ST_CONFIRM &&
                           $past(hits_q) == HIT_W'(LOCK_COUNT - 1))); // R5
endmodule

// File: rtl/lvds_rx_align.sv
module lvds_rx_align
    import rxa_pkg::*;
#(
    parameter int LOCK_COUNT = 4,
    parameter int MISS_LIMIT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pll_lock,
    input  logic [NUM_DATA*NIB_W-1:0]  data_nib,
    input  logic [NIB_W-1:0]           clk_nib,
    output logic [NUM_DATA*WORD_W-1:0] out_word,
    output logic                       out_vld,
    output logic                       aligned
);
    localparam int CLK_LANE = NUM_DATA;

    logic            emit;
    logic [SH_W-1:0] shift;
    logic            raw_vld;
    word_t           raw   [NUM_LANES];
    word_t           prev_q[NUM_LANES];
    logic            primed_q;
    logic [WORD_W-1:0] match;
    offs_t           offset;
    logic            fsm_emit;
    logic            step;
    logic [WIN_W-1:0] clk_win;

    rxa_gear_ctrl u_ctrl (
        .clk(clk), .rst(rst), .emit(emit), .shift(shift), .raw_vld(raw_vld)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [NIB_W-1:0] nib;
        if (l == CLK_LANE) begin : g_clk
            assign nib = clk_nib;
        end else begin : g_dat
            assign nib = data_nib[l*NIB_W +: NIB_W];
        end
        rxa_lane_gear u_gear (
            .clk(clk), .rst(rst), .nib(nib), .emit(emit), .shift(shift),
            .raw_word(raw[l])
        );
        always_ff @(posedge clk) begin
            if (rst) prev_q[l] <= '0;
            else if (raw_vld) prev_q[l] <= raw[l];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pll_lock) primed_q <= 1'b0;
        else if (raw_vld)     primed_q <= 1'b1;
    end

    assign clk_win = {prev_q[CLK_LANE], raw[CLK_LANE]};

    for (genvar k = 0; k < WORD_W; k++) begin : g_match
        assign match[k] = (take_slice(clk_win, CNT_W'(k)) == CLK_SHAPE);
    end

    assign step = raw_vld && primed_q && pll_lock;

    rxa_lock_fsm #(.LOCK_COUNT(LOCK_COUNT), .MISS_LIMIT(MISS_LIMIT)) u_fsm (
        .clk(clk), .rst(rst), .restart(!pll_lock), .step(step), .match(match),
        .offset(offset), .locked(aligned), .emit(fsm_emit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_word <= '0;
        end else begin
            out_vld <= fsm_emit;
            if (fsm_emit) begin
                for (int l = 0; l < NUM_DATA; l++) begin
                    out_word[l*WORD_W +: WORD_W] <= take_slice({prev_q[l], raw[l]}, offset);
                end
            end
        end
    end

    AST_VLD_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> aligned); // R10
    AST_PLL_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !pll_lock |=> (!aligned && !out_vld)); // R9
    AST_OFFSET_HELD: assert property (@(posedge clk) disable iff (rst)
        (aligned && $past(aligned)) |-> $stable(offset)); // R4
endmodule

// File: tb/lvds_rx_align_test.sv
module lvds_rx_align_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pll_lock = 1'b1;
    logic [15:0] data_nib = '0;
    logic [3:0]  clk_nib = '0;
    logic [27:0] out_word;
    logic        out_vld;
    logic        aligned;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int off = 0;
    int cor_from = -100;
    int cor_len = 0;
    int have_base = 0;
    int expect_idx = 0;
    int first_idx = -1;
    int fall_cnt = 0;
    int relocks = 0;
    int delivered = 0;
    bit prev_al = 1'b0;

    always #5 clk = ~clk;

    lvds_rx_align uut (
        .clk(clk), .rst(rst), .pll_lock(pll_lock), .data_nib(data_nib),
        .clk_nib(clk_nib), .out_word(out_word), .out_vld(out_vld), .aligned(aligned)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int data_val(input int lane, input int p);
        if (lane == 0) return p % 128;
        return (p * (2 * lane + 3) + 19 * lane) % 128;
    endfunction

    function automatic logic [6:0] word_of(input int lane, input int p);
        if (lane == 4) begin
            if (p >= cor_from && p < cor_from + cor_len) return 7'b0000000;
            return 7'b1100011;
        end
        return 7'(data_val(lane, p));
    endfunction

    function automatic logic bit_of(input int lane, input int g);
        int r;
        logic [6:0] w;
        if (g < off) return 1'b0;
        r = g - off;
        w = word_of(lane, r / 7);
        return w[6 - (r % 7)];
    endfunction

    task automatic drive_nib(input int c);
        for (int l = 0; l < 5; l++) begin
            for (int b = 0; b < 4; b++) begin
                if (l == 4) clk_nib[3 - b] = bit_of(l, 4 * c + b);
                else data_nib[l * 4 + 3 - b] = bit_of(l, 4 * c + b);
            end
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            drive_nib(cyc);
            @(posedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        pll_lock = 1'b1;
        cyc = 0;
        repeat (3) begin
            drive_nib(0);
            @(posedge clk);
            #1;
        end
        rst = 1'b0;
        fall_cnt = 0;
        relocks = 0;
        delivered = 0;
        first_idx = -1;
    endtask

    // Pixel monitor: sampled away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            have_base = 0;
            prev_al = 1'b0;
        end else begin
            if (prev_al && !aligned) fall_cnt++;
            if (!aligned) have_base = 0;
            if (out_vld) begin
                int idx;
                delivered++;
                check(aligned, "R10 out_vld while unaligned", int'(aligned), 1);
                idx = int'(out_word[6:0]);
                if (have_base == 0) begin
                    have_base = 1;
                    first_idx = idx;
                    relocks++;
                end else begin
                    check(idx == expect_idx, "R3 pixel continuity", idx, expect_idx);
                end
                for (int l = 1; l < 4; l++) begin
                    check(int'(out_word[l*7 +: 7]) == data_val(l, idx),
                          "R2 lane word", int'(out_word[l*7 +: 7]), data_val(l, idx));
                end
                expect_idx = (idx + 1) % 128;
            end
            prev_al = aligned;
        end
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(aligned == 1'b0, "R1 aligned in reset", int'(aligned), 0);
        check(out_vld == 1'b0, "R1 out_vld in reset", int'(out_vld), 0);

        // R3/R4/R5: every bit offset
        for (int o = 0; o < 14; o++) begin
            off = o;
            cor_from = -100;
            cor_len = 0;
            do_reset();
            step(4);
            check(aligned == 1'b0, "R5 no early lock", int'(aligned), 0);
            check(delivered == 0, "R5 no early pixels", delivered, 0);
            step(60);
            check(aligned == 1'b1, "R4 locked at offset", int'(aligned), 1);
            check(first_idx == 3, "R5 first delivered pixel", first_idx, 3);
            check(delivered > 20, "R3 pixels delivered", delivered, 21);
            check(fall_cnt == 0, "R3 no drop", fall_cnt, 0);
        end

        // R6: mismatch during confirmation
        off = 3;
        cor_from = 2;
        cor_len = 1;
        do_reset();
        step(60);
        check(first_idx == 6, "R6 confirm restart", first_idx, 6);
        check(aligned == 1'b1, "R6 locked later", int'(aligned), 1);

        // R7: single miss while aligned
        off = 5;
        cor_from = 20;
        cor_len = 1;
        do_reset();
        step(80);
        check(fall_cnt == 0, "R7 single miss tolerated", fall_cnt, 0);
        check(relocks == 1, "R7 single lock episode", relocks, 1);
        check(aligned == 1'b1, "R7 still aligned", int'(aligned), 1);

        // R8: two consecutive misses
        off = 11;
        cor_from = 20;
        cor_len = 2;
        do_reset();
        step(80);
        check(fall_cnt == 1, "R8 drop count", fall_cnt, 1);
        check(relocks == 2, "R8 relock episodes", relocks, 2);
        check(first_idx == 25, "R8 relock pixel", first_idx, 25);
        check(aligned == 1'b1, "R8 aligned again", int'(aligned), 1);

        // R9: PLL lock loss
        off = 9;
        cor_from = -100;
        cor_len = 0;
        do_reset();
        step(40);
        check(aligned == 1'b1, "R9 locked before loss", int'(aligned), 1);
        pll_lock = 1'b0;
        step(1);
        check(aligned == 1'b0, "R9 aligned after loss", int'(aligned), 0);
        check(out_vld == 1'b0, "R9 out_vld after loss", int'(out_vld), 0);
        for (int i = 0; i < 3; i++) begin
            step(1);
            check(out_vld == 1'b0, "R9 quiet while unlocked", int'(out_vld), 0);
        end
        pll_lock = 1'b1;
        step(50);
        check(aligned == 1'b1, "R9 relocked", int'(aligned), 1);
        check(relocks == 2, "R9 fresh lock episode", relocks, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule